// File: doc/BRIEF.md
# MDIO PHY Management Slave

This block is the management-side slave of an Ethernet PHY. It watches the serial management clock (MDC) and a shared data line split into input, output and output-enable. It decodes clause-22 style frames and answers only those frames aimed at its own PHY address. Writes go into a 32 by 16-bit register file. Reads shift register contents back onto the line. A few read addresses do not return stored contents: they return status words built from the advertisement register, so a host driver sees a link that is always up and always agreed.

MDC and MDIO are oversampled by a faster system clock and passed through synchronizers, so MDC must run well below the system clock. Each MDC half period should last at least four system clocks. The line is assumed to have a pull-up. When the slave does not drive it, the line reads as one.

Top module: `mdio_phy_slave`

## Requirements
- R1: Bits are sampled on rising MDC edges, MSB first, in this fixed order: preamble ones, start bits `0` then `1`, a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits.
- R2: A frame starts only when the low start bit follows at least PRE_LEN (default 32) consecutive sampled ones. A zero seen earlier restarts the count, and the rest of that attempt has no effect on any register.
- R3: Opcode `10` addressed to PHY_ADDR (default 1) is a read. The slave shifts the 16-bit read value out MSB first and changes its output only while MDC is low.
- R4: Opcodes `00`, `01` and `11` are writes. The 16 data bits are stored in the addressed register once the 16th data bit has been sampled, and a later read returns them.
- R5: On a read, mdio_oe stays low through the first turnaround bit. It goes high with mdio_o at 0 for the second turnaround bit, stays high through the 16 data bits, and drops after the 16th rising edge. mdio_oe is low at all other times, including the whole of a write frame and the time after reset.
- R6: For a frame aimed at any other PHY address, the slave never drives the line, so a read sees 0xFFFF. A write to such an address changes no register.
- R7: Register 1 always reads 0x782C (bits 14, 13, 12, 11, 5, 3 and 2 set), whatever was written to it.
- R8: Register 5 reads as 0x4001 OR'd with bits 8:5 of register 4.
- R9: Register 18 reads 0x0C00 when bit 7 or bit 8 of register 4 is set, and 0x0000 otherwise.
- R10: After reset, register 0 holds 0x3100, register 2 holds 0x0300, register 3 holds 0xE400, register 4 holds 0x01E1, and every other stored register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples MDC |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sampled level of the management data line |
| mdio_o | output | 1 | Value the slave drives onto the data line |
| mdio_oe | output | 1 | High while the slave drives the data line |

## Verification
Two situations are hard to reach from the ports. The first is a frame that looks valid but arrives after too short a preamble. Nothing on the outputs shows that it was dropped. The stimulus sends such an attempt as a write with a 20-bit preamble over a register that holds a known pattern, then reads the register back with a proper frame. Writes to a foreign PHY address and writes to the synthesized addresses are handled the same way: each is followed by a read that would expose a stray store, and register 4 is moved through values that set bit 7 alone, bit 8 alone, and neither.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int N_REGS = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_STATUS  = 5'd1;
  localparam logic [ADDR_W-1:0] A_ADVERT  = 5'd4;
  localparam logic [ADDR_W-1:0] A_PARTNER = 5'd5;
  localparam logic [ADDR_W-1:0] A_DIAG    = 5'd18;

  localparam logic [DATA_W-1:0] STATUS_WORD = 16'h782C;
  localparam logic [DATA_W-1:0] PARTNER_FIX = 16'h4001;
  localparam logic [DATA_W-1:0] PARTNER_MSK = 16'h01E0;
  localparam logic [DATA_W-1:0] DIAG_SRC    = 16'h0180;
  localparam logic [DATA_W-1:0] DIAG_WORD   = 16'h0C00;

  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_OPC, ST_PHYA, ST_REGA, ST_TURN, ST_DATA
  } frame_state_e;

  function automatic logic [DATA_W-1:0] reg_reset_value(input int unsigned idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_in,
  input  logic mdio_in,
  output logic mdc_lvl,
  output logic mdio_lvl,
  output logic mdc_rise,
  output logic mdc_fall
);

  logic [STAGES-1:0] mdc_sh, mdio_sh;
  logic              mdc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sh   <= '0;
      mdio_sh  <= '1;
      mdc_prev <= 1'b0;
    end else begin
      mdc_sh   <= {mdc_sh[STAGES-2:0], mdc_in};
      mdio_sh  <= {mdio_sh[STAGES-2:0], mdio_in};
      mdc_prev <= mdc_sh[STAGES-1];
    end
  end

  assign mdc_lvl  = mdc_sh[STAGES-1];
  assign mdio_lvl = mdio_sh[STAGES-1];
  assign mdc_rise = mdc_lvl & ~mdc_prev;
  assign mdc_fall = ~mdc_lvl & mdc_prev;

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [N_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) mem[i] <= reg_reset_value(i);
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  // Status-style addresses are built on read; the stored copy is shadowed.
  always_comb begin
    unique case (addr)
      A_STATUS:  rd_data = STATUS_WORD;
      A_PARTNER: rd_data = PARTNER_FIX | (mem[A_ADVERT] & PARTNER_MSK);
      A_DIAG:    rd_data = |(mem[A_ADVERT] & DIAG_SRC) ? DIAG_WORD : '0;
      default:   rd_data = mem[addr];
    endcase
  end

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(addr)] == $past(wr_data));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_lvl,
  input  logic              mdio_lvl,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0]     PRE_MAX = CW'(PRE_LEN);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PHY_ADDR);
  localparam logic [3:0]        LAST_BIT = 4'(DATA_W - 1);

  frame_state_e      state, state_n;
  logic [CW-1:0]     pre_cnt, pre_n;
  logic [3:0]        bit_cnt, cnt_n;
  logic [1:0]        opc, opc_n;
  logic [ADDR_W-1:0] phy_a, pa_n, reg_a, ra_n;
  logic [DATA_W-1:0] shreg, sh_n;
  logic              rd_go, go_n, out_q, out_n, oe_q, oe_n;
  logic              is_rd, pa_match;

  assign is_rd    = (opc == OP_READ);
  assign pa_match = (phy_a == MY_ADDR);

  always_comb begin
    state_n = state;
    pre_n   = pre_cnt;
    cnt_n   = bit_cnt;
    opc_n   = opc;
    pa_n    = phy_a;
    ra_n    = reg_a;
    sh_n    = shreg;
    go_n    = rd_go;
    out_n   = out_q;
    oe_n    = oe_q;
    if (mdc_rise) begin
      unique case (state)
        ST_HUNT: begin
          if (mdio_lvl) begin
            if (pre_cnt != PRE_MAX) pre_n = pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PRE_MAX) state_n = ST_START;
            pre_n = '0;
          end
        end
        ST_START: begin
          state_n = ST_OPC;
          cnt_n   = '0;
        end
        ST_OPC: begin
          opc_n = {opc[0], mdio_lvl};
          if (bit_cnt == 4'd1) begin
            state_n = ST_PHYA;
            cnt_n   = '0;
          end else cnt_n = bit_cnt + 1'b1;
        end
        ST_PHYA: begin
          pa_n = {phy_a[ADDR_W-2:0], mdio_lvl};
          if (bit_cnt == 4'(ADDR_W - 1)) begin
            state_n = ST_REGA;
            cnt_n   = '0;
          end else cnt_n = bit_cnt + 1'b1;
        end
        ST_REGA: begin
          ra_n = {reg_a[ADDR_W-2:0], mdio_lvl};
          if (bit_cnt == 4'(ADDR_W - 1)) begin
            state_n = ST_TURN;
            cnt_n   = '0;
          end else cnt_n = bit_cnt + 1'b1;
        end
        ST_TURN: begin
          if (bit_cnt == 4'd0) begin
            sh_n  = rd_data;
            go_n  = is_rd && pa_match;
            cnt_n = 4'd1;
          end else begin
            state_n = ST_DATA;
            cnt_n   = '0;
          end
        end
        ST_DATA: begin
          if (!rd_go) sh_n = {shreg[DATA_W-2:0], mdio_lvl};
          if (bit_cnt == LAST_BIT) begin
            state_n = ST_HUNT;
            cnt_n   = '0;
            go_n    = 1'b0;
            oe_n    = 1'b0;
          end else cnt_n = bit_cnt + 1'b1;
        end
        default: state_n = ST_HUNT;
      endcase
    end else if (mdc_fall && rd_go) begin
      if (state == ST_TURN && bit_cnt == 4'd1) begin
        oe_n  = 1'b1;
        out_n = 1'b0;
      end else if (state == ST_DATA) begin
        oe_n  = 1'b1;
        out_n = shreg[DATA_W-1];
        sh_n  = {shreg[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      pre_cnt <= '0;
      bit_cnt <= '0;
      opc     <= '0;
      phy_a   <= '0;
      reg_a   <= '0;
      shreg   <= '0;
      rd_go   <= 1'b0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (mdc_rise || mdc_fall) begin
      state   <= state_n;
      pre_cnt <= pre_n;
      bit_cnt <= cnt_n;
      opc     <= opc_n;
      phy_a   <= pa_n;
      reg_a   <= ra_n;
      shreg   <= sh_n;
      rd_go   <= go_n;
      out_q   <= out_n;
      oe_q    <= oe_n;
    end
  end

  assign reg_addr = reg_a;
  assign wr_en    = mdc_rise && (state == ST_DATA) && (bit_cnt == LAST_BIT) && !is_rd && pa_match;
  assign wr_data  = {shreg[DATA_W-2:0], mdio_lvl};
  assign mdio_o   = out_q;
  assign mdio_oe  = oe_q;

  a_r2_full_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && $past(state) != ST_START) |-> $past(pre_cnt) == PRE_MAX);

  a_r3_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc_lvl);

  a_r5_drive_scope: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (rd_go && (state == ST_TURN || state == ST_DATA)));

  a_r5_turn_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && state == ST_TURN) |-> !mdio_o);

  a_r6_own_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> phy_a == MY_ADDR);

endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave
  import mdio_pkg::*;
#(
  parameter int PHY_ADDR    = 1,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdio_o,
  output logic mdio_oe
);

  logic [1:0]        rst_q;
  logic              rst_sn;
  logic              mdc_lvl, mdio_lvl, mdc_rise, mdc_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sn),
    .mdc_in  (mdc),
    .mdio_in (mdio_i),
    .mdc_lvl (mdc_lvl),
    .mdio_lvl(mdio_lvl),
    .mdc_rise(mdc_rise),
    .mdc_fall(mdc_fall)
  );

  mdio_frame_fsm #(.PHY_ADDR(PHY_ADDR), .PRE_LEN(PRE_LEN)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sn),
    .mdc_lvl (mdc_lvl),
    .mdio_lvl(mdio_lvl),
    .mdc_rise(mdc_rise),
    .mdc_fall(mdc_fall),
    .rd_data (rd_data),
    .reg_addr(reg_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  mdio_phy_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr_en  (wr_en),
    .addr   (reg_addr),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

endmodule

// File: tb/mdio_phy_slave_test.sv
module mdio_phy_slave_test;

  localparam int HALF = 8;
  localparam int SEED = 20240611;

  logic clk = 1'b0;
  logic rst_n;
  logic mdc, m_en, m_val;
  logic mdio_o, mdio_oe;
  wire  line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

  int checks = 0;
  int errors = 0;
  int oe_cycles = 0;
  logic [15:0] model [32];

  always #2.5 clk = ~clk;

  mdio_phy_slave uut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always @(negedge clk) if (mdio_oe) oe_cycles++;

  function automatic logic [15:0] rst_val(input int idx);
    case (idx)
      0: return 16'h3100;
      2: return 16'h0300;
      3: return 16'hE400;
      4: return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] expect_rd(input logic [4:0] pa, input logic [4:0] ra);
    if (pa != 5'd1) return 16'hFFFF;
    case (ra)
      5'd1:  return 16'h782C;
      5'd5:  return 16'h4001 | (model[4] & 16'h01E0);
      5'd18: return ((model[4] & 16'h0180) != 0) ? 16'h0C00 : 16'h0000;
      default: return model[ra];
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    mdc = 1'b0; m_en = 1'b1; m_val = b;
    repeat (HALF) @(negedge clk);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic take_bit(output logic b, output logic oe_at);
    mdc = 1'b0; m_en = 1'b0;
    repeat (HALF) @(negedge clk);
    b = line; oe_at = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_head(input int pre, input logic [1:0] op,
                           input logic [4:0] pa, input logic [4:0] ra);
    for (int i = 0; i < pre; i++) drive_bit(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b1);
    for (int i = 1; i >= 0; i--) drive_bit(op[i]);
    for (int i = 4; i >= 0; i--) drive_bit(pa[i]);
    for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
  endtask

  // R4: any opcode but 10 writes; the model follows only real commits
  task automatic do_write(input int pre, input logic [1:0] op, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] d, input logic commit);
    oe_cycles = 0;
    send_head(pre, op, pa, ra);
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int i = 15; i >= 0; i--) drive_bit(d[i]);
    m_en = 1'b0;
    check("R5 oe during write", 16'(oe_cycles), 16'd0);
    if (commit) model[ra] = d;
  endtask

  task automatic do_read(input int pre, input logic [4:0] pa, input logic [4:0] ra,
                         input string req);
    logic [15:0] got;
    logic b, oe1, oe2, v2, oe_any_low;
    send_head(pre, 2'b10, pa, ra);
    take_bit(b, oe1);
    take_bit(v2, oe2);
    oe_any_low = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      logic o;
      take_bit(got[i], o);
      if (!o) oe_any_low = 1'b1;
    end
    check(req, got, expect_rd(pa, ra));
    if (pa == 5'd1) begin
      check("R5 turnaround", {13'd0, oe1, oe2, v2}, 16'b010);
      check("R5 held through data", {15'd0, oe_any_low}, 16'd0);
    end else begin
      check("R6 no drive at turnaround", {14'd0, oe1, oe2}, 16'd0);
    end
    check("R5 released after data", {15'd0, mdio_oe}, 16'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(SEED));
    for (int i = 0; i < 32; i++) model[i] = rst_val(i);
    mdc = 1'b0; m_en = 1'b0; m_val = 1'b1; rst_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R5 oe low after reset", {15'd0, mdio_oe}, 16'd0);

    // R10 reset contents; R1 exact 32-bit preamble boundary
    do_read(32, 5'd1, 5'd0, "R10 reg0");
    do_read(32, 5'd1, 5'd2, "R10 reg2");
    do_read(32, 5'd1, 5'd3, "R10 reg3");
    do_read(32, 5'd1, 5'd4, "R10 reg4");
    do_read(32, 5'd1, 5'd9, "R10 reg9");
    do_read(33, 5'd1, 5'd1, "R7 status");
    do_read(32, 5'd1, 5'd5, "R8 partner reset");
    do_read(32, 5'd1, 5'd18, "R9 diag reset");

    // R7: writes to register 1 do not alter its read value
    do_write(32, 2'b01, 5'd1, 5'd1, 16'h0000, 1'b1);
    do_read(32, 5'd1, 5'd1, "R7 status after write");

    // R8 R9 with bit 8 only, bit 7 only, neither
    do_write(32, 2'b01, 5'd1, 5'd4, 16'h0120, 1'b1);
    do_read(32, 5'd1, 5'd5, "R8 partner bit8");
    do_read(32, 5'd1, 5'd18, "R9 diag bit8");
    do_write(32, 2'b01, 5'd1, 5'd4, 16'h0080, 1'b1);
    do_read(32, 5'd1, 5'd5, "R8 partner bit7");
    do_read(32, 5'd1, 5'd18, "R9 diag bit7");
    do_write(32, 2'b01, 5'd1, 5'd4, 16'hFE7F, 1'b1);
    do_read(32, 5'd1, 5'd5, "R8 partner mixed");
    do_read(32, 5'd1, 5'd18, "R9 diag clear");

    // R4 opcodes 00 and 11 also write
    do_write(32, 2'b00, 5'd1, 5'd9, 16'hA5C3, 1'b1);
    do_read(32, 5'd1, 5'd9, "R4 op00 write");
    do_write(32, 2'b11, 5'd1, 5'd31, 16'h8001, 1'b1);
    do_read(32, 5'd1, 5'd31, "R4 op11 write");

    // R2 short preamble attempt is dropped
    do_write(32, 2'b01, 5'd1, 5'd7, 16'hAAAA, 1'b1);
    do_write(20, 2'b01, 5'd1, 5'd7, 16'h0000, 1'b0);
    do_read(32, 5'd1, 5'd7, "R2 short preamble ignored");
    do_write(31, 2'b01, 5'd1, 5'd7, 16'h0000, 1'b0);
    do_read(32, 5'd1, 5'd7, "R2 31 ones ignored");

    // R6 foreign address
    do_write(32, 2'b01, 5'd2, 5'd7, 16'h1234, 1'b0);
    do_read(32, 5'd1, 5'd7, "R6 foreign write ignored");
    do_read(32, 5'd3, 5'd0, "R6 foreign read all ones");

    // R1 R3 random traffic
    for (int n = 0; n < 40; n++) begin
      logic [4:0] pa, ra;
      logic [15:0] d;
      r  = $urandom;
      ra = 5'(r[4:0]);
      pa = (r[7:5] == 3'd0) ? 5'(r[12:8]) : 5'd1;
      d  = 16'($urandom);
      if (r[13]) do_write(32 + int'(r[16:14]), (r[17] ? 2'b01 : 2'b00), pa, ra, d, pa == 5'd1);
      else       do_read(32 + int'(r[16:14]), pa, ra, "R3 random read");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule